// File: doc/BRIEF.md
# Implication Candidate Profiler

This block watches a vector of circuit sites while input vectors are applied, and collects the data needed to propose logic implications for an online error checker. A fixed set of site pairs is wired in through parameters. Each pair names an antecedent site A, a consequent site B and a pivot site P. For every pair the block records which joint values of (A,B) have occurred. It records them once over all samples, and once again for each value of the pivot site. A joint value that never occurs is the signature of an implication. A joint value that is missing in only one pivot half is the signature of a residual implication, which holds only under that pivot value.

Samples count only on cycles where the valid strobe is high. A synchronous clear starts a new profiling run. Candidate flags stay suppressed until enough samples have been seen, so a freshly cleared profile does not report every combination as a candidate. A host selects a pair with an index and reads the three masks and the three candidate vectors in the same cycle.

Each 4-bit mask and candidate vector is indexed by k = 2*A + B. Bit 0 stands for (A,B) = 00, bit 1 for 01, bit 2 for 10 and bit 3 for 11. A missing combination (x,y) reads as the candidate "A = x implies B = not y".

Top module: `impl_profiler`

## Requirements
- R1: After reset, and after any cycle with `clr` high, every mask and every candidate vector of every pair reads zero.
- R2: A cycle with `smp_valid` high and `clr` low sets bit k = 2*A + B of the pair's unsplit mask. Bits once set stay set until reset or clear.
- R3: The same bit is also set in the pivot-0 mask when the pair's pivot site is 0, or in the pivot-1 mask when it is 1. The other half mask does not change. The unsplit mask always equals the union of the two half masks.
- R4: While `smp_valid` is low, site values have no effect on any mask or candidate vector.
- R5: When `clr` and `smp_valid` are both high in one cycle, the clear wins and the sample is discarded.
- R6: Once a pair has seen at least MIN_SAMPLES valid samples, `rd_cand_all` is the bitwise inverse of `rd_mask_all`. Bit k set means combination k was never seen, read as "A = k[1] implies B = not k[0]". Before that point `rd_cand_all` is zero.
- R7: Bit k of the residual vector for pivot half h is set when three conditions all hold: combination k is absent from half h's mask, it is present in the unsplit mask, and half h has seen at least MIN_SAMPLES valid samples.
- R8: A pair whose unsplit mask is full (all four combinations seen) reports no simple candidate.
- R9: `rd_idx` selects a pair, and all six read outputs show that pair's state in the same cycle. Pairs are independent. With the default maps, pair i uses A = site 2i, B = site 2i+1, and pivot site 5, 6, 7, 0 for i = 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all profiles |
| smp_valid | input | 1 | Site sample is valid this cycle |
| smp_sites | input | N_SITES | Sampled site values |
| rd_idx | input | IDX_W | Pair selected for readout |
| rd_mask_all | output | 4 | Unsplit occurrence mask |
| rd_mask_p0 | output | 4 | Occurrence mask while pivot is 0 |
| rd_mask_p1 | output | 4 | Occurrence mask while pivot is 1 |
| rd_cand_all | output | 4 | Simple implication candidates |
| rd_cand_p0 | output | 4 | Residual candidates under pivot 0 |
| rd_cand_p1 | output | 4 | Residual candidates under pivot 1 |

## Verification
The sample stream starts with a short run of all-zero vectors. This separates the early suppression of candidates from the point where the sample count reaches its threshold. A run of all-one vectors with the strobe low, and a single all-one vector with the strobe high, separate strobe gating from mask update and show the routing into the correct pivot half. A hand-built stream for one pair lacks combination 10 only while the pivot is low, so a residual candidate appears with no simple candidate. A full maximal-length pseudo-random sweep fills every mask, and the simple candidates must vanish while the readout of other pairs stays independent.

// File: rtl/ipf_pkg.sv
// Package: shared types and helpers for the implication profiler.
// Assumes a two-site combination is coded as k = 2*A + B.
package ipf_pkg;

    typedef logic [3:0] combo_mask_t;

    // One-hot code of the observed (A,B) combination.
    function automatic combo_mask_t combo_onehot(input logic a, input logic b);
        combo_mask_t m;
        m = 4'b0001 << {a, b};
        return m;
    endfunction

endpackage

// File: rtl/ipf_sat_counter.sv
// Module: saturating sample counter.
// Counts increment pulses up to LIMIT and then holds. The full flag says
// that LIMIT samples have been seen. Assumes LIMIT >= 1.
module ipf_sat_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic full
);
    localparam int CNTW = $clog2(LIMIT + 1);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(LIMIT);

    logic [CNTW-1:0] cnt_q;

    // Count valid samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CNT_TOP);

    // Once full, the flag stays set until a clear (R6 gating stays open).
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> full);

endmodule

// File: rtl/ipf_pair_tracker.sv
// Module: occurrence tracker for one site pair.
// Keeps one 4-bit mask per pivot half. The unsplit mask is their union.
// Three saturating counters gate candidate reporting.
// Assumes the inputs are already selected from the sample vector.
module ipf_pair_tracker
    import ipf_pkg::*;
#(
    parameter int MIN_SAMPLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        valid,
    input  logic        site_a,
    input  logic        site_b,
    input  logic        site_p,
    output combo_mask_t mask_all,
    output combo_mask_t mask_p0,
    output combo_mask_t mask_p1,
    output logic        ready_all,
    output logic        ready_p0,
    output logic        ready_p1
);
    combo_mask_t hit;
    combo_mask_t m0_q;
    combo_mask_t m1_q;
    logic        inc_p0;
    logic        inc_p1;

    // Decode the observed combination into its one-hot code.
    always_comb hit = combo_onehot(site_a, site_b);

    assign inc_p0 = valid && !site_p;
    assign inc_p1 = valid &&  site_p;

    // Accumulate occurrences into the half selected by the pivot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            m0_q <= '0;
            m1_q <= '0;
        end else begin
            if (inc_p0) m0_q <= m0_q | hit;
            if (inc_p1) m1_q <= m1_q | hit;
        end
    end

    assign mask_p0  = m0_q;
    assign mask_p1  = m1_q;
    assign mask_all = m0_q | m1_q;

    ipf_sat_counter #(.LIMIT(MIN_SAMPLES)) u_cnt_all (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(valid), .full(ready_all)
    );
    ipf_sat_counter #(.LIMIT(MIN_SAMPLES)) u_cnt_p0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_p0), .full(ready_p0)
    );
    ipf_sat_counter #(.LIMIT(MIN_SAMPLES)) u_cnt_p1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_p1), .full(ready_p1)
    );

    // A clear, even alongside a valid sample, empties every mask (R1, R5).
    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask_p0 == 4'h0 && mask_p1 == 4'h0));

    // Set bits are never lost without a clear (R2).
    assert_sticky_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((mask_all & $past(mask_all)) == $past(mask_all)));

    // No strobe means no change (R4).
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !valid) |=> ($stable(mask_p0) && $stable(mask_p1)));

    // A sample with the pivot low leaves the pivot-1 half alone, and the reverse (R3).
    assert_route_p0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && valid && !site_p) |=> $stable(mask_p1));
    assert_route_p1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && valid && site_p) |=> $stable(mask_p0));

endmodule

// File: rtl/ipf_cand_decode.sv
// Module: candidate decoder for one pair.
// A zero mask bit becomes a candidate flag once enough samples exist.
// Residual flags need the combination to be present in the unsplit mask.
module ipf_cand_decode
    import ipf_pkg::*;
(
    input  combo_mask_t mask_all,
    input  combo_mask_t mask_p0,
    input  combo_mask_t mask_p1,
    input  logic        ready_all,
    input  logic        ready_p0,
    input  logic        ready_p1,
    output combo_mask_t cand_all,
    output combo_mask_t cand_p0,
    output combo_mask_t cand_p1
);
    // Map never-seen combinations to simple and residual candidates.
    always_comb begin
        cand_all = ready_all ? ~mask_all            : '0;
        cand_p0  = ready_p0  ? (~mask_p0 & mask_all) : '0;
        cand_p1  = ready_p1  ? (~mask_p1 & mask_all) : '0;
    end
endmodule

// File: rtl/impl_profiler.sv
// Module: implication candidate profiler (top).
// Builds N_PAIRS trackers. Each pair takes its A, B and pivot sites from
// 8-bit fields of the map parameters; field i sits at [8*i +: 8].
// Readout is a same-cycle mux on rd_idx. Unused index slots read zero.
// Assumes every map field is below N_SITES.
module impl_profiler
    import ipf_pkg::*;
#(
    parameter int N_SITES     = 8,
    parameter int N_PAIRS     = 4,
    parameter int MIN_SAMPLES = 4,
    parameter logic [N_PAIRS*8-1:0] SITE_A_MAP = 32'h06_04_02_00,
    parameter logic [N_PAIRS*8-1:0] SITE_B_MAP = 32'h07_05_03_01,
    parameter logic [N_PAIRS*8-1:0] PIVOT_MAP  = 32'h00_07_06_05,
    localparam int IDX_W = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               smp_valid,
    input  logic [N_SITES-1:0] smp_sites,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [3:0]         rd_mask_all,
    output logic [3:0]         rd_mask_p0,
    output logic [3:0]         rd_mask_p1,
    output logic [3:0]         rd_cand_all,
    output logic [3:0]         rd_cand_p0,
    output logic [3:0]         rd_cand_p1
);
    localparam int N_SLOTS = 1 << IDX_W;

    combo_mask_t ma  [N_SLOTS];
    combo_mask_t m0  [N_SLOTS];
    combo_mask_t m1  [N_SLOTS];
    combo_mask_t ca  [N_SLOTS];
    combo_mask_t c0  [N_SLOTS];
    combo_mask_t c1  [N_SLOTS];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        if (g < N_PAIRS) begin : g_pair
            localparam int IA = int'(SITE_A_MAP[8*g +: 8]);
            localparam int IB = int'(SITE_B_MAP[8*g +: 8]);
            localparam int IP = int'(PIVOT_MAP[8*g +: 8]);

            logic rdy_all, rdy_p0, rdy_p1;

            ipf_pair_tracker #(.MIN_SAMPLES(MIN_SAMPLES)) u_track (
                .clk(clk), .rst_n(rst_n), .clr(clr), .valid(smp_valid),
                .site_a(smp_sites[IA]), .site_b(smp_sites[IB]),
                .site_p(smp_sites[IP]),
                .mask_all(ma[g]), .mask_p0(m0[g]), .mask_p1(m1[g]),
                .ready_all(rdy_all), .ready_p0(rdy_p0), .ready_p1(rdy_p1)
            );

            ipf_cand_decode u_dec (
                .mask_all(ma[g]), .mask_p0(m0[g]), .mask_p1(m1[g]),
                .ready_all(rdy_all), .ready_p0(rdy_p0), .ready_p1(rdy_p1),
                .cand_all(ca[g]), .cand_p0(c0[g]), .cand_p1(c1[g])
            );

            // A fully covered pair offers no simple candidate (R8).
            assert_full_no_simple_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (ma[g] == 4'hF) |-> (ca[g] == 4'h0));

            // Residual flags name only combinations seen somewhere (R7).
            assert_residual_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ((c0[g] & ~ma[g]) == 4'h0) && ((c1[g] & ~ma[g]) == 4'h0));
        end else begin : g_unused
            assign ma[g] = '0;
            assign m0[g] = '0;
            assign m1[g] = '0;
            assign ca[g] = '0;
            assign c0[g] = '0;
            assign c1[g] = '0;
        end
    end

    // Present the selected pair's state on the read port.
    always_comb begin
        rd_mask_all = ma[rd_idx];
        rd_mask_p0  = m0[rd_idx];
        rd_mask_p1  = m1[rd_idx];
        rd_cand_all = ca[rd_idx];
        rd_cand_p0  = c0[rd_idx];
        rd_cand_p1  = c1[rd_idx];
    end

endmodule

// File: tb/impl_profiler_bench.sv
// Bench: scoreboard check of the implication profiler against a reference model.
module impl_profiler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 8;
    localparam int NP  = 4;
    localparam int MIN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          smp_valid = 1'b0;
    logic [NS-1:0] smp_sites = '0;
    logic [1:0]    rd_idx = '0;
    logic [3:0]    rd_mask_all, rd_mask_p0, rd_mask_p1;
    logic [3:0]    rd_cand_all, rd_cand_p0, rd_cand_p1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        int         idx;
        string      req;
        logic [3:0] ma, m0, m1, ca, c0, c1;
    } exp_t;
    exp_t sb_q[$];

    // Reference model state
    logic [3:0] r_m0 [NP];
    logic [3:0] r_m1 [NP];
    int         k_all [NP];
    int         k0 [NP];
    int         k1 [NP];

    impl_profiler u_impl_profiler (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
        .smp_sites(smp_sites), .rd_idx(rd_idx),
        .rd_mask_all(rd_mask_all), .rd_mask_p0(rd_mask_p0), .rd_mask_p1(rd_mask_p1),
        .rd_cand_all(rd_cand_all), .rd_cand_p0(rd_cand_p0), .rd_cand_p1(rd_cand_p1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int piv_of(input int i);
        case (i)
            0: return 5;
            1: return 6;
            2: return 7;
            default: return 0;
        endcase
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NP; i++) begin
            r_m0[i] = '0; r_m1[i] = '0;
            k_all[i] = 0; k0[i] = 0; k1[i] = 0;
        end
    endtask

    // Driver: apply one cycle of stimulus, then update the model.
    task automatic drive(input logic [NS-1:0] s, input logic v, input logic c);
        smp_sites = s; smp_valid = v; clr = c;
        @(posedge clk); #1;
        smp_valid = 1'b0; clr = 1'b0;
        if (c) model_clear();
        else if (v) begin
            for (int i = 0; i < NP; i++) begin
                int k;
                k = 2 * int'(s[2*i]) + int'(s[2*i+1]);
                if (s[piv_of(i)]) begin
                    r_m1[i][k] = 1'b1;
                    if (k1[i] < MIN) k1[i]++;
                end else begin
                    r_m0[i][k] = 1'b1;
                    if (k0[i] < MIN) k0[i]++;
                end
                if (k_all[i] < MIN) k_all[i]++;
            end
        end
    endtask

    // Driver: push the expected readout for one pair into the scoreboard.
    task automatic check_pair(input int idx, input string req);
        exp_t e;
        logic [3:0] ua;
        ua    = r_m0[idx] | r_m1[idx];
        e.idx = idx; e.req = req;
        e.ma  = ua; e.m0 = r_m0[idx]; e.m1 = r_m1[idx];
        e.ca  = (k_all[idx] >= MIN) ? ~ua : 4'h0;
        e.c0  = (k0[idx] >= MIN) ? (~r_m0[idx] & ua) : 4'h0;
        e.c1  = (k1[idx] >= MIN) ? (~r_m1[idx] & ua) : 4'h0;
        rd_idx = 2'(idx);
        sb_q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic cmp(input string req, input string what, input int idx,
                       input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pair %0d %s: actual %h expected %h", req, idx, what, act, exp);
        end
    endtask

    // Monitor: compare the read port against the oldest expected item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.req, "mask_all", e.idx, rd_mask_all, e.ma);
            cmp(e.req, "mask_p0",  e.idx, rd_mask_p0,  e.m0);
            cmp(e.req, "mask_p1",  e.idx, rd_mask_p1,  e.m1);
            cmp(e.req, "cand_all", e.idx, rd_cand_all, e.ca);
            cmp(e.req, "cand_p0",  e.idx, rd_cand_p0,  e.c0);
            cmp(e.req, "cand_p1",  e.idx, rd_cand_p1,  e.c1);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of every pair
        for (int i = 0; i < NP; i++) check_pair(i, "R1");

        // R6: three samples leave candidates suppressed
        for (int i = 0; i < 3; i++) drive(8'h00, 1'b1, 1'b0);
        check_pair(0, "R6");
        drive(8'h00, 1'b1, 1'b0);
        check_pair(0, "R6");
        check_pair(2, "R6");

        // R4: strobe low, sites toggling
        drive(8'hFF, 1'b0, 1'b0);
        drive(8'hA5, 1'b0, 1'b0);
        check_pair(0, "R4");
        check_pair(1, "R4");

        // R2, R3: one all-ones sample lands in pivot-1 half
        drive(8'hFF, 1'b1, 1'b0);
        check_pair(0, "R2");
        check_pair(3, "R3");

        // R5: clear wins over a valid sample
        drive(8'h0F, 1'b1, 1'b1);
        check_pair(0, "R5");
        check_pair(2, "R5");

        // R7: pair 0 lacks 10 only while pivot (site 5) is low
        for (int r = 0; r < MIN; r++) begin
            drive(8'b0000_0000, 1'b1, 1'b0);
            drive(8'b0000_0010, 1'b1, 1'b0);
            drive(8'b0000_0011, 1'b1, 1'b0);
            drive(8'b0010_0001, 1'b1, 1'b0);
            drive(8'b0010_0000, 1'b1, 1'b0);
            drive(8'b0010_0010, 1'b1, 1'b0);
            drive(8'b0010_0011, 1'b1, 1'b0);
        end
        check_pair(0, "R7");
        check_pair(1, "R9");

        // R8: full pseudo-random sweep covers every combination
        lfsr = 8'h5A;
        for (int n = 0; n < 255; n++) begin
            drive(lfsr, 1'b1, 1'b0);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        for (int i = 0; i < NP; i++) check_pair(i, "R8");
        for (int i = NP - 1; i >= 0; i--) check_pair(i, "R9");

        // R1: clear alone empties everything again
        drive(8'h00, 1'b0, 1'b1);
        for (int i = 0; i < NP; i++) check_pair(i, "R1");

        @(posedge clk); #1;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule